// File: doc/BRIEF.md
# Single-Format Instruction Decoder and Control Unit

This block is the control unit of a small 8-bit single-cycle processor. It accepts one 22-bit instruction word, breaks it into an opcode, three register indexes and an 8-bit immediate, and drives every strobe and select that the datapath needs for that instruction. It has no clock and no storage, and it never sees register or memory contents. The same cycle's instruction word fully determines every output.

The opcode is decoded one-hot. The decoded lines are then grouped into write enables, writeback and ALU-operand selects, jump and branch controls. The ALU operation comes from a priority encoder whose lowest level is tied active, so addition is selected whenever no other group claims the instruction. Writeback to the register file can come from the ALU, the immediate, data memory or the link value PC+1. Register 0 reads as zero in the register file, so this unit withholds the register write enable whenever the destination index is 0.

Top module: `isa_ctl_decoder`

## Requirements
- R1: The instruction fields are: opcode = bits 21:17, rd = bits 16:14, rs = bits 13:11, rt = bits 10:8, imm = bits 7:0. rdIdx, rsIdx, rtIdx and immVal always equal these fields.
- R2: Opcode numbering: 0 hlt, 1 put, 2 li, 3 mov, 4 add, 5 sub, 6 and, 7 or, 8 xor, 9 not, 10 shl, 11 shr, 12 adi, 13 sbi, 14 ani, 15 ori, 16 xri, 17 sli, 18 sri, 19 ld, 20 st, 21 j, 22 jr, 23 jal, 24 jlr, 25 blt, 26 bge, 27 beq, 28 bne. haltOut is 1 for opcode 0 only, so the all-zero word halts.
- R3: dispWe is 1 for put (opcode 1) only. The display takes REG[rs] as its high byte and REG[rt] as its low byte.
- R4: regWe is 1 for li, mov, opcodes 4 to 18, ld, jal and jlr, but only when rd is nonzero. It is 0 for every other opcode, including st.
- R5: wbSel picks the write data. The codes are 0 for the ALU result, 1 for imm (li), 2 for memory read data (ld) and 3 for PC+1 (jal, jlr). Every other opcode gives 0.
- R6: aluOp codes are 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 not, 6 shl, 7 shr. The register and immediate forms share a code: sub/sbi 1, and/ani 2, or/ori 3, xor/xri 4, not 5, shl/sli 6, shr/sri 7. Every other opcode, including add, adi, ld, st and mov, gives 0.
- R7: aluBSel is 1 (imm) for opcodes 12 to 20 and 2 (constant zero) for mov, so that mov passes REG[rs] through the adder. Every other opcode gives 0 (REG[rt]).
- R8: memWe is 1 for st (opcode 20) only and never for ld. The address is REG[rs]+imm through the ALU, and the store data is REG[rt].
- R9: jumpOut is 1 for j, jr, jal and jlr. jumpFromReg is 1 for jr and jlr, which take their target from REG[rs]. j and jal take the target from imm. jumpFromReg is 0 for all other opcodes.
- R10: branchEn is 1 for opcodes 25 to 28. branchCond is 0 lt, 1 ge, 2 eq, 3 ne, comparing REG[rs] with REG[rt], and is 0 for any opcode that is not a branch.
- R11: Opcodes 29, 30 and 31 drive haltOut, dispWe, regWe, memWe, jumpOut, jumpFromReg and branchEn to 0, and all selects to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 22 | Instruction word of the current cycle |
| rdIdx | output | 3 | Destination register index |
| rsIdx | output | 3 | First source register index |
| rtIdx | output | 3 | Second source register index |
| immVal | output | 8 | Immediate / target / branch offset |
| haltOut | output | 1 | Freeze the program counter |
| dispWe | output | 1 | Display write enable |
| regWe | output | 1 | Register file write enable |
| wbSel | output | 2 | Register write data source |
| aluOp | output | 3 | ALU operation code |
| aluBSel | output | 2 | ALU B operand source |
| memWe | output | 1 | Data memory write enable |
| jumpOut | output | 1 | Unconditional jump |
| jumpFromReg | output | 1 | Jump target from REG[rs] instead of imm |
| branchEn | output | 1 | Conditional branch instruction |
| branchCond | output | 2 | Branch comparison kind |

## Verification
Two functions can act on one word: a link jump (jal, jlr) raises the jump strobe and also the register write with the PC+1 source, and the r0 write guard can cancel that same write. Random words with all field bits free hit both, and directed words put each opcode against rd = 0 and rd = 7. Each output is compared on its own against a table model in the bench, so a wrongly suppressed link write or a missing jump is reported on the output concerned.

// File: rtl/cpu_ctl_pkg.sv
package cpu_ctl_pkg;

  localparam int INSTR_W = 22;
  localparam int OPC_W   = 5;
  localparam int REG_W   = 3;
  localparam int IMM_W   = 8;
  localparam int ALUOP_W = 3;
  localparam int NUM_OPC = 1 << OPC_W;

  // field positions, most significant first
  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int RD_LSB  = OPC_LSB - REG_W;
  localparam int RS_LSB  = RD_LSB - REG_W;
  localparam int RT_LSB  = RS_LSB - REG_W;

  // opcode numbering
  localparam int OP_HLT = 0;
  localparam int OP_PUT = 1;
  localparam int OP_LI  = 2;
  localparam int OP_MOV = 3;
  localparam int OP_ADD = 4;
  localparam int OP_SUB = 5;
  localparam int OP_AND = 6;
  localparam int OP_OR  = 7;
  localparam int OP_XOR = 8;
  localparam int OP_NOT = 9;
  localparam int OP_SHL = 10;
  localparam int OP_SHR = 11;
  localparam int OP_ADI = 12;
  localparam int OP_SBI = 13;
  localparam int OP_ANI = 14;
  localparam int OP_ORI = 15;
  localparam int OP_XRI = 16;
  localparam int OP_SLI = 17;
  localparam int OP_SRI = 18;
  localparam int OP_LD  = 19;
  localparam int OP_ST  = 20;
  localparam int OP_J   = 21;
  localparam int OP_JR  = 22;
  localparam int OP_JAL = 23;
  localparam int OP_JLR = 24;
  localparam int OP_BLT = 25;
  localparam int OP_BGE = 26;
  localparam int OP_BEQ = 27;
  localparam int OP_BNE = 28;

  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_IMM  = 2'd1,
    WB_MEM  = 2'd2,
    WB_LINK = 2'd3
  } wbSel_e;

  typedef enum logic [1:0] {
    BSRC_RT   = 2'd0,
    BSRC_IMM  = 2'd1,
    BSRC_ZERO = 2'd2
  } bSel_e;

  typedef enum logic [1:0] {
    BR_LT = 2'd0,
    BR_GE = 2'd1,
    BR_EQ = 2'd2,
    BR_NE = 2'd3
  } brCond_e;

  typedef struct packed {
    logic                 halt;
    logic                 dispWe;
    logic                 regWe;
    wbSel_e               wbSel;
    logic [ALUOP_W-1:0]   aluOp;
    bSel_e                bSel;
    logic                 memWe;
    logic                 jump;
    logic                 jumpReg;
    logic                 branch;
    brCond_e              brCond;
  } ctlStrobes_t;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs;
    logic [REG_W-1:0] rt;
    logic [IMM_W-1:0] imm;
  } instrFields_t;

endpackage

// File: rtl/instr_fields.sv
module instr_fields
  import cpu_ctl_pkg::*;
#(
  parameter int WORD_W = INSTR_W
) (
  input  logic [WORD_W-1:0] word,
  output instrFields_t      fields
);
  localparam int FIELD_SUM = OPC_W + 3 * REG_W + IMM_W;

  if (FIELD_SUM != WORD_W) begin : g_badWidth
    initial $error("instr_fields: field widths do not fill the word");
  end

  always_comb begin
    fields.opc = word[OPC_LSB +: OPC_W];
    fields.rd  = word[RD_LSB  +: REG_W];
    fields.rs  = word[RS_LSB  +: REG_W];
    fields.rt  = word[RT_LSB  +: REG_W];
    fields.imm = word[0       +: IMM_W];
  end
endmodule

// File: rtl/opcode_decoder.sv
module opcode_decoder #(
  parameter int SEL_W = 5,
  localparam int LINES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] opc,
  output logic [LINES-1:0] hot
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign hot[i] = (opc == SEL_W'(i));
  end
endmodule

// File: rtl/alu_op_encoder.sv
module alu_op_encoder #(
  parameter int SEL_W = 3,
  localparam int LEVELS = 1 << SEL_W
) (
  input  logic [LEVELS-1:1] req,
  output logic [SEL_W-1:0]  code
);
  // level 0 (addition) is permanently requested; the highest active level wins
  always_comb begin
    code = '0;
    for (int i = 1; i < LEVELS; i++) begin
      if (req[i]) code = SEL_W'(i);
    end
  end
endmodule

// File: rtl/ctl_strobe_gen.sv
module ctl_strobe_gen
  import cpu_ctl_pkg::*;
(
  input  logic [NUM_OPC-1:0] hot,
  input  logic               rdNonZero,
  output ctlStrobes_t        strobes
);
  localparam int ALU_LEVELS = 1 << ALUOP_W;

  logic [ALU_LEVELS-1:1] aluReq;
  logic [ALUOP_W-1:0]    aluCode;
  logic writesRd, immOperand, linkWrite, isBranch, isJump;

  // requests per ALU level, register and immediate forms merged
  always_comb begin
    aluReq    = '0;
    aluReq[1] = hot[OP_SUB] | hot[OP_SBI];
    aluReq[2] = hot[OP_AND] | hot[OP_ANI];
    aluReq[3] = hot[OP_OR]  | hot[OP_ORI];
    aluReq[4] = hot[OP_XOR] | hot[OP_XRI];
    aluReq[5] = hot[OP_NOT];
    aluReq[6] = hot[OP_SHL] | hot[OP_SLI];
    aluReq[7] = hot[OP_SHR] | hot[OP_SRI];
  end

  alu_op_encoder #(.SEL_W(ALUOP_W)) u_aluEnc (
    .req  (aluReq),
    .code (aluCode)
  );

  always_comb begin
    linkWrite  = hot[OP_JAL] | hot[OP_JLR];
    writesRd   = hot[OP_LI] | hot[OP_MOV] | (|hot[OP_SRI:OP_ADD])
               | hot[OP_LD] | linkWrite;
    immOperand = |hot[OP_ST:OP_ADI];
    isJump     = hot[OP_J] | hot[OP_JR] | linkWrite;
    isBranch   = |hot[OP_BNE:OP_BLT];

    strobes         = '0;
    strobes.halt    = hot[OP_HLT];
    strobes.dispWe  = hot[OP_PUT];
    strobes.regWe   = writesRd & rdNonZero;
    strobes.memWe   = hot[OP_ST];
    strobes.aluOp   = aluCode;
    strobes.jump    = isJump;
    strobes.jumpReg = hot[OP_JR] | hot[OP_JLR];
    strobes.branch  = isBranch;

    if (hot[OP_LI])     strobes.wbSel = WB_IMM;
    else if (hot[OP_LD]) strobes.wbSel = WB_MEM;
    else if (linkWrite) strobes.wbSel = WB_LINK;
    else                strobes.wbSel = WB_ALU;

    if (immOperand)       strobes.bSel = BSRC_IMM;
    else if (hot[OP_MOV]) strobes.bSel = BSRC_ZERO;
    else                  strobes.bSel = BSRC_RT;

    if (hot[OP_BGE])      strobes.brCond = BR_GE;
    else if (hot[OP_BEQ]) strobes.brCond = BR_EQ;
    else if (hot[OP_BNE]) strobes.brCond = BR_NE;
    else                  strobes.brCond = BR_LT;
  end
endmodule

// File: rtl/isa_ctl_decoder.sv
module isa_ctl_decoder
  import cpu_ctl_pkg::*;
(
  input  logic [21:0] instr,
  output logic [2:0]  rdIdx,
  output logic [2:0]  rsIdx,
  output logic [2:0]  rtIdx,
  output logic [7:0]  immVal,
  output logic        haltOut,
  output logic        dispWe,
  output logic        regWe,
  output logic [1:0]  wbSel,
  output logic [2:0]  aluOp,
  output logic [1:0]  aluBSel,
  output logic        memWe,
  output logic        jumpOut,
  output logic        jumpFromReg,
  output logic        branchEn,
  output logic [1:0]  branchCond
);
  instrFields_t        fields;
  logic [NUM_OPC-1:0]  hot;
  ctlStrobes_t         strobes;

  instr_fields #(.WORD_W(INSTR_W)) u_fields (
    .word   (instr),
    .fields (fields)
  );

  opcode_decoder #(.SEL_W(OPC_W)) u_opcDec (
    .opc (fields.opc),
    .hot (hot)
  );

  ctl_strobe_gen u_strobes (
    .hot       (hot),
    .rdNonZero (|fields.rd),
    .strobes   (strobes)
  );

  assign rdIdx       = fields.rd;
  assign rsIdx       = fields.rs;
  assign rtIdx       = fields.rt;
  assign immVal      = fields.imm;
  assign haltOut     = strobes.halt;
  assign dispWe      = strobes.dispWe;
  assign regWe       = strobes.regWe;
  assign wbSel       = strobes.wbSel;
  assign aluOp       = strobes.aluOp;
  assign aluBSel     = strobes.bSel;
  assign memWe       = strobes.memWe;
  assign jumpOut     = strobes.jump;
  assign jumpFromReg = strobes.jumpReg;
  assign branchEn    = strobes.branch;
  assign branchCond  = strobes.brCond;

  // cross-checks between the field splitter and the strobe generator
  always_comb begin
    if (!$isunknown(instr)) begin
      a_r2_halt_quiet: assert (!haltOut || !(regWe | memWe | dispWe | jumpOut | branchEn))
        else $error("halt word raised another strobe");
      a_r4_no_r0_write: assert (rdIdx != 3'd0 || !regWe)
        else $error("register write aimed at r0");
      a_r8_store_no_regwrite: assert (!memWe || (!regWe && aluBSel == 2'd1))
        else $error("store wrote a register or used a register offset");
      a_r10_flow_exclusive: assert ($onehot0({jumpOut, branchEn, memWe, dispWe, haltOut}))
        else $error("flow and write strobes overlap");
      a_r5_link_source: assert (!(jumpOut && regWe) || wbSel == 2'd3)
        else $error("linking jump wrote a value other than PC+1");
      a_r9_regtarget_is_jump: assert (!jumpFromReg || jumpOut)
        else $error("register target selected without a jump");
    end
  end
endmodule

// File: tb/sim_isa_ctl_decoder.sv
module sim_isa_ctl_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [21:0] instr;
  logic [2:0]  rdIdx, rsIdx, rtIdx, aluOp;
  logic [7:0]  immVal;
  logic        haltOut, dispWe, regWe, memWe, jumpOut, jumpFromReg, branchEn;
  logic [1:0]  wbSel, aluBSel, branchCond;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  isa_ctl_decoder u0 (
    .instr(instr), .rdIdx(rdIdx), .rsIdx(rsIdx), .rtIdx(rtIdx), .immVal(immVal),
    .haltOut(haltOut), .dispWe(dispWe), .regWe(regWe), .wbSel(wbSel),
    .aluOp(aluOp), .aluBSel(aluBSel), .memWe(memWe), .jumpOut(jumpOut),
    .jumpFromReg(jumpFromReg), .branchEn(branchEn), .branchCond(branchCond)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s instr=%h actual=%0d expected=%0d", tag, instr, act, exp);
    end
  endtask

  // expected-value model built from the requirement tables
  task automatic checkWord();
    int op = int'(instr[21:17]);
    int rd = int'(instr[16:14]);
    int eWb = 0, eAlu = 0, eB = 0, eCond = 0;
    bit eReg = 0, eJump = 0, eJreg = 0, eBr = 0;
    case (op)
      2:  begin eReg = 1; eWb = 1; end
      3:  begin eReg = 1; eB = 2; end
      19: begin eReg = 1; eWb = 2; eB = 1; end
      20: eB = 1;
      21: eJump = 1;
      22: begin eJump = 1; eJreg = 1; end
      23: begin eJump = 1; eReg = 1; eWb = 3; end
      24: begin eJump = 1; eJreg = 1; eReg = 1; eWb = 3; end
      default: ;
    endcase
    if (op >= 4 && op <= 11) begin eReg = 1; eAlu = op - 4; end
    if (op >= 12 && op <= 18) begin
      eReg = 1; eB = 1;
      eAlu = (op == 12) ? 0 : (op <= 16 ? op - 12 : op - 11);
    end
    if (op >= 25 && op <= 28) begin eBr = 1; eCond = op - 25; end
    if (rd == 0) eReg = 0;
    chk("R1 rd",  int'(rdIdx),  rd);
    chk("R1 rs",  int'(rsIdx),  int'(instr[13:11]));
    chk("R1 rt",  int'(rtIdx),  int'(instr[10:8]));
    chk("R1 imm", int'(immVal), int'(instr[7:0]));
    chk("R2 halt", int'(haltOut), int'(op == 0));
    chk("R3 dispWe", int'(dispWe), int'(op == 1));
    chk("R4 regWe", int'(regWe), int'(eReg));
    chk("R5 wbSel", int'(wbSel), eWb);
    chk("R6 aluOp", int'(aluOp), eAlu);
    chk("R7 aluBSel", int'(aluBSel), eB);
    chk("R8 memWe", int'(memWe), int'(op == 20));
    chk("R9 jump", int'(jumpOut), int'(eJump));
    chk("R9 jumpFromReg", int'(jumpFromReg), int'(eJreg));
    chk("R10 branchEn", int'(branchEn), int'(eBr));
    chk("R10 branchCond", int'(branchCond), eCond);
    if (op >= 29) begin  // R11 unassigned opcodes stay silent
      chk("R11 quiet", int'({haltOut, dispWe, regWe, memWe, jumpOut, jumpFromReg, branchEn}), 0);
    end
  endtask

  task automatic apply(input logic [21:0] w);
    @(posedge clk);
    #1 instr = w;
    @(negedge clk);
    checkWord();
  endtask

  initial begin
    instr = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // reset state: the all-zero word is a halt (R2)
    chk("R2 reset halt", int'(haltOut), 1);
    chk("R4 reset regWe", int'(regWe), 0);
    // directed: every opcode with rd = 7 and rd = 0 (R4, R11)
    for (int op = 0; op < 32; op++) begin
      apply({5'(op), 3'd7, 3'd2, 3'd5, 8'hA6});
      apply({5'(op), 3'd0, 3'd7, 3'd0, 8'hFF});
    end
    // directed: link jumps that also write (R5, R9)
    apply({5'd23, 3'd7, 3'd0, 3'd0, 8'h05});
    apply({5'd24, 3'd1, 3'd3, 3'd0, 8'h00});
    // random words with a fixed seed
    void'($urandom(32'h5eed));
    for (int n = 0; n < 3000; n++) begin
      apply(22'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule